// File: doc/BRIEF.md
# Dual-Select Asynchronous SRAM Sequencer

This block lets synchronous logic use an external 128K x 8 asynchronous static RAM that has one active-low and one active-high chip select. A client hands it one read or one write at a time over a valid/ready handshake, with a 17-bit address and a byte of data. The block then drives the memory's address, both selects, the active-low output and write strobes, and a split data bus (output value, output enable, input value) for an external tri-state pad. Each access lasts a fixed number of clock cycles, and inside that window each strobe is placed so that the memory's minimum pulse, setup and recovery times hold.

Writes are strobe-timed. The write strobe falls after both selects and the address have settled, and it rises one cycle before the access ends, so the address and data are still held after the rising edge. Reads keep the output strobe low for the whole window and capture the byte on the final cycle. After a read the memory's drivers can take several cycles to release the bus. A write that follows a read is therefore held off until that time has passed.

A retention input parks the memory in its deepest deselect state, with the high-side select low, and blocks new work. An access already under way is allowed to finish first. When retention is released, the block waits one full access time with the memory deselected before it accepts a new request.

Top module: `sram_dual_cs_ctrl`

## Requirements
- R1: After reset, with no retention request, all pin outputs are inactive: cs1_n high, cs2 high, oe_n high, we_n high, dq_oe low. rsp_done is low and req_ready is high.
- R2: A request is taken only on a cycle in which req_valid and req_ready are both high. req_ready is low for the whole of an access, and the memory stays deselected while nothing has been accepted.
- R3: A read holds cs1_n low, cs2 high, oe_n low, we_n high and dq_oe low for exactly ACC_CYC (7) consecutive cycles, starting the cycle after acceptance. It then returns to the idle pins, cs1_n high and cs2 high.
- R4: The byte present on mem_dq_in during the last read cycle appears on rsp_rdata in the following cycle, together with rsp_done.
- R5: A write holds oe_n high and drives we_n low for exactly WE_CYC (4) cycles, at access phases ACC_CYC-1-WE_CYC through ACC_CYC-2 (phases 2 to 5, counting from 0). This leaves one recovery cycle with we_n high before the selects are released.
- R6: dq_oe is high only during the ACC_CYC cycles of a write, and for all of those cycles mem_dq_out carries the accepted write byte.
- R7: mem_addr equals the accepted address and does not change in any cycle of an access, including the cycle after we_n rises.
- R8: After a read ends, a write request sees req_ready low until oe_n has been high for TURN_CYC (3) cycles, so dq_oe rises no earlier than TURN_CYC cycles after oe_n. A read request needs no such wait.
- R9: While ret_req is high in idle, the block parks the memory with cs1_n high, cs2 low, oe_n high and we_n high. It raises ret_active, keeps req_ready low and starts no access, even if req_valid is high.
- R10: A retention request that arrives during an access does not cut that access short. The access finishes with its normal rsp_done and data, and the memory is parked on the following cycle.
- R11: After ret_req falls, req_ready stays low and the selects stay in idle (cs1_n high, cs2 high) for ACC_CYC cycles. Requests are accepted again from the next cycle.
- R12: rsp_done is a single-cycle pulse, one per access, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (17) | Byte address |
| req_wdata | input | DATA_W (8) | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W (8) | Byte returned by the last read |
| ret_req | input | 1 | Level request to park the memory for retention |
| ret_active | output | 1 | Memory is parked in retention |
| mem_addr | output | ADDR_W (17) | Memory address pins |
| mem_cs1_n | output | 1 | Active-low select |
| mem_cs2 | output | 1 | Active-high select |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | DATA_W (8) | Value for the data pad |
| mem_dq_oe | output | 1 | Pad output enable |
| mem_dq_in | input | DATA_W (8) | Value read back from the data pad |

## Verification
The assertions assume that the client holds req_write and req_addr steady while req_valid waits for req_ready. They also assume that ret_req is a clean synchronous level. The bench changes every input half a period after the clock edge and releases req_valid right after an acceptance. The memory model drives mem_dq_in only while both selects are active and oe_n is low, and it returns a byte computed from the address. This keeps every read check independent of earlier writes.

// File: rtl/sram_ctrl_pkg.sv
// Package shared by the SRAM sequencer: the controller's state encoding.
// Assumes nothing beyond a two-bit state register.
package sram_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_PARKED  = 2'd2,
        ST_WAKE    = 2'd3
    } ctrl_state_e;
endpackage

// File: rtl/sram_phase_cnt.sv
// Phase counter for one timed window (an access, or the wake-up delay).
// It restarts at zero when clr is high, counts up and saturates at LEN-1.
// It presents both the registered phase and the value it will hold next,
// so that pins can be registered from the next state.
// Assumes LEN >= 2.
module sram_phase_cnt #(
    parameter int LEN = 7,
    localparam int PW = (LEN > 1) ? $clog2(LEN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [PW-1:0] phase_q,
    output logic [PW-1:0] phase_nxt,
    output logic          at_last
);
    localparam logic [PW-1:0] LAST = PW'(LEN - 1);

    // Next phase: restart, else step up until saturated.
    always_comb begin
        if (clr)                 phase_nxt = '0;
        else if (phase_q == LAST) phase_nxt = phase_q;
        else                     phase_nxt = phase_q + 1'b1;
    end

    assign at_last = (phase_q == LAST);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= LAST;
        else        phase_q <= phase_nxt;
    end

    // R3: the phase never passes the end of the window.
    a_r3_phase_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST);
endmodule

// File: rtl/sram_turn_guard.sv
// Bus turnaround guard. After a read ends, it counts the cycles during
// which the memory may still drive the data bus, and reports when our
// own pad may be enabled. Assumes read_end is a single-cycle pulse on
// the edge that closes a read.
module sram_turn_guard #(
    parameter int TURN_CYC = 3,
    localparam int TW = $clog2(TURN_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic read_end,
    output logic turn_ok
);
    localparam logic [TW-1:0] FULL = TW'(TURN_CYC);
    logic [TW-1:0] cnt_q;

    // Cycles since oe_n was released, counting the first idle cycle as 1.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= FULL;
        else if (read_end)     cnt_q <= TW'(1);
        else if (cnt_q < FULL) cnt_q <= cnt_q + 1'b1;
    end

    assign turn_ok = (cnt_q >= FULL);

    // R8: a fresh read end always closes the window for at least one cycle.
    a_r8_guard_closes: assert property (@(posedge clk) disable iff (!rst_n)
        read_end && (TURN_CYC > 1) |=> !turn_ok);
endmodule

// File: rtl/sram_pin_decode.sv
// Maps controller state, operation and access phase onto memory pin levels.
// Pure combinational logic: the top registers its outputs. It assumes the
// phase counts 0..ACC_CYC-1 across an access.
module sram_pin_decode
    import sram_ctrl_pkg::*;
#(
    parameter int ACC_CYC = 7,
    parameter int WE_CYC  = 4,
    localparam int PW = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1
) (
    input  ctrl_state_e   state,
    input  logic          is_write,
    input  logic [PW-1:0] phase,
    output logic          cs1_n,
    output logic          cs2,
    output logic          oe_n,
    output logic          we_n,
    output logic          dq_oe
);
    localparam logic [PW-1:0] WE_FIRST = PW'(ACC_CYC - 1 - WE_CYC);
    localparam logic [PW-1:0] WE_LAST  = PW'(ACC_CYC - 2);

    logic in_we_window;
    assign in_we_window = (phase >= WE_FIRST) && (phase <= WE_LAST);

    // Pin levels for each controller state.
    always_comb begin
        cs1_n = 1'b1;
        cs2   = 1'b1;
        oe_n  = 1'b1;
        we_n  = 1'b1;
        dq_oe = 1'b0;
        unique case (state)
            ST_ACCESS: begin
                cs1_n = 1'b0;
                oe_n  = is_write;
                we_n  = !(is_write && in_we_window);
                dq_oe = is_write;
            end
            ST_PARKED: cs2 = 1'b0;
            default: ;
        endcase
    end
endmodule

// File: rtl/sram_dual_cs_ctrl.sv
// Sequencer for an external asynchronous SRAM with one active-low and one
// active-high select. It runs one access at a time from a valid/ready request,
// times every strobe in clock cycles, holds writes back after reads until
// the bus has turned around, and parks the memory for retention.
// Assumes req_write/req_addr/req_wdata are stable while req_valid waits, and
// that the clock period times ACC_CYC covers the memory's cycle time.
module sram_dual_cs_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int ACC_CYC  = 7,
    parameter int WE_CYC   = 4,
    parameter int TURN_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              ret_req,
    output logic              ret_active,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int PW = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;
    localparam int OW = $clog2(TURN_CYC + 2);

    ctrl_state_e   st_q, st_nxt;
    logic          op_wr_q, op_wr_nxt;
    logic          accept, turn_ok, ph_last, read_end;
    logic [PW-1:0] ph_q, ph_nxt;
    logic          d_cs1_n, d_cs2, d_oe_n, d_we_n, d_dq_oe;

    assign accept    = req_valid && req_ready;
    assign req_ready = (st_q == ST_IDLE) && !ret_req && (!req_write || turn_ok);
    assign read_end  = (st_q == ST_ACCESS) && ph_last && !op_wr_q;
    assign op_wr_nxt = accept ? req_write : op_wr_q;
    assign ret_active = (st_q == ST_PARKED);

    // Next-state choice; retention is taken before any new access.
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE:   if (ret_req) st_nxt = ST_PARKED;
                       else if (accept) st_nxt = ST_ACCESS;
            ST_ACCESS: if (ph_last) st_nxt = ST_IDLE;
            ST_PARKED: if (!ret_req) st_nxt = ST_WAKE;
            ST_WAKE:   if (ret_req) st_nxt = ST_PARKED;
                       else if (ph_last) st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    sram_phase_cnt #(.LEN(ACC_CYC)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (st_nxt != st_q),
        .phase_q   (ph_q),
        .phase_nxt (ph_nxt),
        .at_last   (ph_last)
    );

    sram_turn_guard #(.TURN_CYC(TURN_CYC)) u_turn (
        .clk      (clk),
        .rst_n    (rst_n),
        .read_end (read_end),
        .turn_ok  (turn_ok)
    );

    sram_pin_decode #(.ACC_CYC(ACC_CYC), .WE_CYC(WE_CYC)) u_pins (
        .state    (st_nxt),
        .is_write (op_wr_nxt),
        .phase    (ph_nxt),
        .cs1_n    (d_cs1_n),
        .cs2      (d_cs2),
        .oe_n     (d_oe_n),
        .we_n     (d_we_n),
        .dq_oe    (d_dq_oe)
    );

    // State and latched operation type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            op_wr_q <= 1'b0;
        end else begin
            st_q    <= st_nxt;
            op_wr_q <= op_wr_nxt;
        end
    end

    // Registered strobes, so the memory sees clean edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs1_n <= 1'b1;
            mem_cs2   <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_cs1_n <= d_cs1_n;
            mem_cs2   <= d_cs2;
            mem_oe_n  <= d_oe_n;
            mem_we_n  <= d_we_n;
            mem_dq_oe <= d_dq_oe;
        end
    end

    // Address and write byte are loaded on acceptance and held until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Completion pulse and read capture on the last access cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= (st_q == ST_ACCESS) && ph_last;
            if (read_end) rsp_rdata <= mem_dq_in;
        end
    end

    // Checker state: cycles for which oe_n has been high, saturating.
    logic [OW-1:0] oe_hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                        oe_hi_cnt <= OW'(TURN_CYC);
        else if (!mem_oe_n)                oe_hi_cnt <= '0;
        else if (oe_hi_cnt < OW'(TURN_CYC)) oe_hi_cnt <= oe_hi_cnt + 1'b1;
    end

    a_r2_ready_only_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_cs1_n);
    a_r5_we_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs1_n && mem_cs2 && mem_oe_n));
    a_r6_drive_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_cs1_n && mem_oe_n));
    a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));
    a_r8_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_hi_cnt >= OW'(TURN_CYC)));
    a_r9_parked_pins: assert property (@(posedge clk) disable iff (!rst_n)
        ret_active |-> (mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !req_ready));
    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r4_done_after_select: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> ($past(!mem_cs1_n) && mem_cs1_n));
endmodule

// File: tb/sram_dual_cs_ctrl_bench.sv
// Directed bench for the SRAM sequencer. It contains a behavioural memory
// model, one task per scenario, and samples the outputs at the falling edge.
module sram_dual_cs_ctrl_bench;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int ACC = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, ret_req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_done, ret_active;
    logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [AW-1:0] mem_addr;
    logic          mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [AW-1:0] wr_seen_addr;
    logic [DW-1:0] wr_seen_data;

    always #2 clk = ~clk;

    sram_dual_cs_ctrl u_sram_dual_cs_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ret_req(ret_req),
        .ret_active(ret_active), .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n),
        .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ {1'b0, a[16:10]} ^ 8'hA5;
    endfunction

    // Memory model: drives read data only when selected with oe_n low.
    assign mem_dq_in = (!mem_cs1_n && mem_cs2 && !mem_oe_n) ? pat(mem_addr) : 8'h00;

    // Record what the memory stores at the rising edge of the write strobe.
    always @(posedge mem_we_n) begin
        if (mem_cs1_n === 1'b0 && mem_cs2 === 1'b1) begin
            wr_seen_addr <= mem_addr;
            wr_seen_data <= mem_dq_out;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic accept_req(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        #1 check("R2 ready before accept", req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Ends on the falling edge of the rsp_done cycle.
    task automatic t_read(input logic [AW-1:0] a);
        accept_req(1'b0, a, 8'h00);
        for (int i = 0; i < ACC; i++) begin
            check("R3 cs1_n low", mem_cs1_n, 0);
            check("R3 oe_n low", mem_oe_n, 0);
            check("R3 we_n high", mem_we_n, 1);
            check("R3 dq_oe low", mem_dq_oe, 0);
            check("R7 read addr", mem_addr, a);
            check("R2 ready low in access", req_ready, 0);
            @(negedge clk);
        end
        check("R4 done", rsp_done, 1);
        check("R4 rdata", rsp_rdata, pat(a));
        check("R3 idle cs1_n", mem_cs1_n, 1);
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        accept_req(1'b1, a, d);
        for (int i = 0; i < ACC; i++) begin
            check("R5 we_n phase", mem_we_n, (i >= 2 && i <= 5) ? 0 : 1);
            check("R5 oe_n high", mem_oe_n, 1);
            check("R6 dq_oe", mem_dq_oe, 1);
            check("R6 dq_out", mem_dq_out, d);
            check("R7 write addr", mem_addr, a);
            @(negedge clk);
        end
        check("R12 write done", rsp_done, 1);
        check("R6 dq_oe off", mem_dq_oe, 0);
        check("R5 stored addr", wr_seen_addr, a);
        check("R5 stored data", wr_seen_data, d);
        @(negedge clk);
        check("R12 done one cycle", rsp_done, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 cs1_n", mem_cs1_n, 1);
        check("R1 cs2", mem_cs2, 1);
        check("R1 oe_n", mem_oe_n, 1);
        check("R1 we_n", mem_we_n, 1);
        check("R1 dq_oe", mem_dq_oe, 0);
        check("R1 done", rsp_done, 0);
        check("R1 ready", req_ready, 1);
        repeat (3) begin
            @(negedge clk);
            check("R2 no access idle", mem_cs1_n, 1);
        end
    endtask

    task automatic t_read_pair;
        t_read(17'h1_2345);
        @(negedge clk);
        check("R12 read done one cycle", rsp_done, 0);
        req_write = 1'b0;
        req_valid = 1'b1;
        #1 check("R8 read needs no wait", req_ready, 1);
        req_valid = 1'b0;
        t_read(17'h0_0F0F);
        @(negedge clk);
    endtask

    task automatic t_turnaround;
        t_read(17'h1_FFFF);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h0_0042; req_wdata = 8'h3C;
        #1 check("R8 ready low c0", req_ready, 0);
        @(negedge clk);
        #1 check("R8 ready low c1", req_ready, 0);
        @(negedge clk);
        #1 check("R8 ready high c2", req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 dq_oe after gap", mem_dq_oe, 1);
        for (int i = 1; i < ACC + 1; i++) @(negedge clk);
        check("R12 done after turn write", rsp_done, 1);
        check("R6 stored turn data", wr_seen_data, 8'h3C);
        @(negedge clk);
    endtask

    task automatic t_retention;
        @(negedge clk);
        ret_req = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h0_0777;
        #1 check("R9 ready low", req_ready, 0);
        @(negedge clk);
        check("R9 ret_active", ret_active, 1);
        check("R9 cs1_n", mem_cs1_n, 1);
        check("R9 cs2 low", mem_cs2, 0);
        check("R9 oe_n", mem_oe_n, 1);
        check("R9 we_n", mem_we_n, 1);
        repeat (3) begin
            @(negedge clk);
            check("R9 no access parked", mem_cs1_n, 1);
            check("R9 still parked", mem_cs2, 0);
        end
        req_valid = 1'b0;
        ret_req = 1'b0;
        for (int i = 0; i < ACC; i++) begin
            @(negedge clk);
            #1 check("R11 ready low wake", req_ready, 0);
            check("R11 cs2 idle", mem_cs2, 1);
            check("R11 cs1_n idle", mem_cs1_n, 1);
        end
        @(negedge clk);
        #1 check("R11 ready after wake", req_ready, 1);
    endtask

    task automatic t_ret_mid_access;
        accept_req(1'b0, 17'h0_5A5A, 8'h00);
        @(negedge clk);
        @(negedge clk);
        ret_req = 1'b1; req_valid = 1'b1; req_addr = 17'h0_0001;
        for (int i = 2; i < ACC; i++) begin
            check("R10 access continues", mem_cs1_n, 0);
            @(negedge clk);
        end
        check("R10 done", rsp_done, 1);
        check("R10 rdata", rsp_rdata, pat(17'h0_5A5A));
        #1 check("R10 ready low", req_ready, 0);
        @(negedge clk);
        check("R10 parked", ret_active, 1);
        check("R10 cs2 low", mem_cs2, 0);
        check("R10 no new access", mem_cs1_n, 1);
        req_valid = 1'b0;
        ret_req = 1'b0;
        repeat (ACC + 2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_pair();
        t_write(17'h1_0203, 8'hC7);
        t_write(17'h0_0000, 8'h00);
        t_turnaround();
        t_retention();
        t_ret_mid_access();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule